// File: doc/BRIEF.md
# Framed Serial Sample Streamer

The streamer sends a burst of sample words out on one data line with a bit clock beside it, once per multiplexer frame. A frame-start trigger from an outside sequencer starts the burst. On that trigger the block copies a parallel bundle of sample words and one flag bit per word into a shadow store. It then shifts the copy out as framed words. Each word opens with its flag bit, and its data bits follow from the least significant up to the sign bit.

Every burst lasts a fixed budget of bit slots, so it always ends well before the next compute pass. Each slot takes two core clock cycles. The bit clock is low in the first cycle of a slot and high in the second, so a receiver can latch on the rising bit-clock edge. The slots left over after the last word stay quiet. While the block is busy, further triggers have no effect. When the enable is low, the line stays silent.

Top module: `sample_streamer`

## Requirements
- R1: After reset, busy_o, sdata_o and sclk_o are all low.
- R2: A rising clock edge that sees en_i=1, trig_i=1 and busy_o=0 starts a burst. busy_o goes high from that edge and stays high for exactly 2*FRAME_SLOTS clock cycles (280 with defaults), then falls.
- R3: Slot s (counted from 0, two cycles per slot) with s < NUM_WORDS*(WORD_W+1) belongs to word w = s/(WORD_W+1), where word w is words_i[w*WORD_W +: WORD_W]. Position p = s mod (WORD_W+1) carries flag_i[w] when p = 0, and word bit p-1 otherwise, so bit 0 goes first and the sign bit WORD_W-1 goes last.
- R4: sclk_o is low in the first cycle of each data slot and high in the second. sdata_o does not change between the two cycles of a slot.
- R5: In the padding slots from NUM_WORDS*(WORD_W+1) up to FRAME_SLOTS-1, busy_o stays high while sdata_o and sclk_o stay low.
- R6: Changes on words_i and flags_i after the starting edge do not alter the burst in progress.
- R7: A trigger seen while busy_o is high is ignored, including one on the final busy cycle. A trigger held high is accepted on the first edge where busy_o is low, so busy_o is low for exactly one cycle between bursts.
- R8: From the edge after en_i is seen low, busy_o, sdata_o and sclk_o are low. Any burst in progress is abandoned, and triggers are ignored while en_i stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, two cycles per bit slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low silences and aborts |
| trig_i | input | 1 | Frame-start trigger |
| words_i | input | NUM_WORDS*WORD_W | Packed sample words, word 0 in the low bits |
| flags_i | input | NUM_WORDS | One flag bit per word, bit w for word w |
| sdata_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Bit clock that goes with sdata_o |
| busy_o | output | 1 | High for the whole burst budget |

## Verification
Two functions can fall in the same clock edge: the end of a burst and the arrival of a new trigger. The bench provokes the first case by raising the trigger in the last busy cycle, and expects busy_o to stay low afterwards. In a second run it holds the trigger high across the end of the burst. There it expects exactly one idle cycle, and then a second burst that matches the expected slot pattern bit for bit. A trigger raised in the middle of a burst, and an enable dropped in the middle of a burst, are also judged cycle by cycle against the slot model.

// File: rtl/streamer_pkg.sv
package streamer_pkg;
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;
endpackage

// File: rtl/streamer_shadow.sv
module streamer_shadow #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [NUM_WORDS*WORD_W-1:0]   words_in,
   input  logic [NUM_WORDS-1:0]          flags_in,
   output logic [NUM_WORDS*WORD_W-1:0]   words_q,
   output logic [NUM_WORDS-1:0]          flags_q
);
   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words_q[k*WORD_W +: WORD_W] <= '0;
            flags_q[k]                  <= 1'b0;
         end else if (load) begin
            words_q[k*WORD_W +: WORD_W] <= words_in[k*WORD_W +: WORD_W];
            flags_q[k]                  <= flags_in[k];
         end
      end
   end
endmodule

// File: rtl/streamer_seq.sv
module streamer_seq
   import streamer_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int NUM_WORDS   = 4,
   parameter int FRAME_SLOTS = 140,
   localparam int WIW = $clog2(NUM_WORDS + 1),
   localparam int BIW = $clog2(WORD_W + 1),
   localparam int SW  = $clog2(FRAME_SLOTS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic           trig,
   output logic           busy,
   output logic           load,
   output phase_e         phase,
   output logic [WIW-1:0] word_idx,
   output logic [BIW-1:0] bit_idx
);
   localparam logic [SW-1:0]  LAST_SLOT = SW'(FRAME_SLOTS - 1);
   localparam logic [BIW-1:0] LAST_POS  = BIW'(WORD_W);
   localparam logic [WIW-1:0] WORD_END  = WIW'(NUM_WORDS);

   logic [SW-1:0] slot_q;

   assign load = en && trig && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         phase    <= PH_LOW;
         slot_q   <= '0;
         word_idx <= '0;
         bit_idx  <= '0;
      end else if (!en) begin
         busy     <= 1'b0;
         phase    <= PH_LOW;
         slot_q   <= '0;
         word_idx <= '0;
         bit_idx  <= '0;
      end else if (load) begin
         busy     <= 1'b1;
         phase    <= PH_LOW;
         slot_q   <= '0;
         word_idx <= '0;
         bit_idx  <= '0;
      end else if (busy) begin
         if (phase == PH_LOW) begin
            phase <= PH_HIGH;
         end else begin
            phase <= PH_LOW;
            if (slot_q == LAST_SLOT) begin
               busy <= 1'b0;
            end
            slot_q <= slot_q + 1'b1;
            if (bit_idx == LAST_POS) begin
               bit_idx <= '0;
               if (word_idx < WORD_END) begin
                  word_idx <= word_idx + 1'b1;
               end
            end else begin
               bit_idx <= bit_idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/streamer_mux.sv
module streamer_mux
   import streamer_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 4,
   localparam int WIW = $clog2(NUM_WORDS + 1),
   localparam int BIW = $clog2(WORD_W + 1)
) (
   input  logic [NUM_WORDS*WORD_W-1:0] words_q,
   input  logic [NUM_WORDS-1:0]        flags_q,
   input  logic                        busy,
   input  phase_e                      phase,
   input  logic [WIW-1:0]              word_idx,
   input  logic [BIW-1:0]              bit_idx,
   output logic                        sdata,
   output logic                        sclk
);
   localparam logic [WIW-1:0] WORD_END = WIW'(NUM_WORDS);

   logic [WORD_W-1:0] word_sel;
   logic              flag_sel;
   logic [WORD_W-1:0] shifted;
   logic [BIW-1:0]    pos;
   logic              in_data;

   always_comb begin
      word_sel = '0;
      flag_sel = 1'b0;
      for (int k = 0; k < NUM_WORDS; k++) begin
         if (word_idx == WIW'(k)) begin
            word_sel = words_q[k*WORD_W +: WORD_W];
            flag_sel = flags_q[k];
         end
      end
   end

   assign pos     = bit_idx - 1'b1;
   assign shifted = word_sel >> pos;
   assign in_data = busy && (word_idx < WORD_END);
   assign sdata   = in_data && ((bit_idx == '0) ? flag_sel : shifted[0]);
   assign sclk    = in_data && (phase == PH_HIGH);
endmodule

// File: rtl/sample_streamer.sv
module sample_streamer
   import streamer_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int NUM_WORDS   = 4,
   parameter int FRAME_SLOTS = 140
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en_i,
   input  logic                        trig_i,
   input  logic [NUM_WORDS*WORD_W-1:0] words_i,
   input  logic [NUM_WORDS-1:0]        flags_i,
   output logic                        sdata_o,
   output logic                        sclk_o,
   output logic                        busy_o
);
   localparam int WIW = $clog2(NUM_WORDS + 1);
   localparam int BIW = $clog2(WORD_W + 1);

   if (WORD_W < 2) begin : g_bad_width
      $error("WORD_W must be at least 2");
   end
   if (NUM_WORDS < 1) begin : g_bad_count
      $error("NUM_WORDS must be at least 1");
   end
   if (FRAME_SLOTS < NUM_WORDS * (WORD_W + 1)) begin : g_bad_budget
      $error("FRAME_SLOTS too small for the framed words");
   end

   logic                        load;
   phase_e                      phase;
   logic [WIW-1:0]              word_idx;
   logic [BIW-1:0]              bit_idx;
   logic [NUM_WORDS*WORD_W-1:0] words_q;
   logic [NUM_WORDS-1:0]        flags_q;

   streamer_seq #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .FRAME_SLOTS(FRAME_SLOTS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en_i), .trig(trig_i),
      .busy(busy_o), .load(load), .phase(phase),
      .word_idx(word_idx), .bit_idx(bit_idx)
   );

   streamer_shadow #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(load),
      .words_in(words_i), .flags_in(flags_i),
      .words_q(words_q), .flags_q(flags_q)
   );

   streamer_mux #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)
   ) u_mux (
      .words_q(words_q), .flags_q(flags_q), .busy(busy_o), .phase(phase),
      .word_idx(word_idx), .bit_idx(bit_idx),
      .sdata(sdata_o), .sclk(sclk_o)
   );
endmodule

// File: rtl/streamer_chk.sv
module streamer_chk #(
   parameter int WORD_W      = 32,
   parameter int NUM_WORDS   = 4,
   parameter int FRAME_SLOTS = 140
) (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic trig_i,
   input logic sdata_o,
   input logic sclk_o,
   input logic busy_o
);
   localparam int CW = $clog2(2 * FRAME_SLOTS + 1);
   localparam logic [CW-1:0] LIM = CW'(2 * FRAME_SLOTS);
   localparam logic [CW-1:0] PAD = CW'(2 * NUM_WORDS * (WORD_W + 1));

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (busy_o) cnt_q <= cnt_q + 1'b1;
      else             cnt_q <= '0;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!sclk_o && !sdata_o)); // R1
   AST_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && $past(en_i)) |-> (cnt_q == LIM)); // R2
   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cnt_q < LIM)); // R2
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> $stable(sdata_o)); // R4
   AST_PAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (cnt_q >= PAD)) |-> (!sclk_o && !sdata_o)); // R5
   AST_START_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(trig_i && en_i)); // R7
   AST_EN_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!busy_o && !sclk_o && !sdata_o)); // R8
endmodule

bind sample_streamer streamer_chk #(
   .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .FRAME_SLOTS(FRAME_SLOTS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en_i(en_i), .trig_i(trig_i),
   .sdata_o(sdata_o), .sclk_o(sclk_o), .busy_o(busy_o)
);

// File: tb/test_sample_streamer.sv
`timescale 1ns/1ps
module test_sample_streamer;
   localparam int W = 32;
   localparam int N = 4;
   localparam int FS = 140;
   localparam int DATA_SLOTS = N * (W + 1);
   localparam int BUSY_CYC = 2 * FS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_i = 1'b0;
   logic trig_i = 1'b0;
   logic [N*W-1:0] words_i = '0;
   logic [N-1:0] flags_i = '0;
   logic sdata_o, sclk_o, busy_o;

   int n_checks = 0;
   int n_fails = 0;

   always #2.5 clk = ~clk;

   sample_streamer #(.WORD_W(W), .NUM_WORDS(N), .FRAME_SLOTS(FS)) i_sample_streamer (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .trig_i(trig_i),
      .words_i(words_i), .flags_i(flags_i),
      .sdata_o(sdata_o), .sclk_o(sclk_o), .busy_o(busy_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic quiet_chk(input string req);
      chk({req, " busy"}, 32'(busy_o), 32'd0);
      chk({req, " sdata"}, 32'(sdata_o), 32'd0);
      chk({req, " sclk"}, 32'(sclk_o), 32'd0);
   endtask

   // mode 0 plain, 1 inputs change mid burst (R6), 2 triggers while busy (R7),
   // 3 trigger held across the end of the burst (R7)
   task automatic run_frame(input logic [N*W-1:0] w, input logic [N-1:0] f,
                            input int mode, input bit started);
      if (!started) begin
         @(negedge clk);
         words_i = w;
         flags_i = f;
         trig_i = 1'b1;
         @(negedge clk);
      end
      trig_i = 1'b0;
      for (int j = 0; j < BUSY_CYC; j++) begin
         int slot = j / 2;
         logic ed, ec;
         string rq;
         if (slot < DATA_SLOTS) begin
            int wi = slot / (W + 1);
            int bi = slot % (W + 1);
            ed = (bi == 0) ? f[wi] : w[wi*W + bi - 1];
            ec = (j % 2 == 1);
            rq = (mode == 1) ? "R6" : "R3";
         end else begin
            ed = 1'b0;
            ec = 1'b0;
            rq = "R5";
         end
         chk({rq, " sdata"}, 32'(sdata_o), 32'(ed));
         chk((slot < DATA_SLOTS) ? "R4 sclk" : "R5 sclk", 32'(sclk_o), 32'(ec));
         chk("R2 busy high", 32'(busy_o), 32'd1);
         if (mode == 1 && j == 50) begin
            words_i = ~w;
            flags_i = ~f;
         end
         if (mode == 2) trig_i = (j == 100 || j == BUSY_CYC - 1);
         if (mode == 3) trig_i = (j == BUSY_CYC - 1);
         @(negedge clk);
      end
      chk("R2 busy falls", 32'(busy_o), 32'd0);
      if (mode == 3) begin
         @(negedge clk);
         trig_i = 1'b0;
         chk("R7 restart after one idle cycle", 32'(busy_o), 32'd1);
      end else begin
         trig_i = 1'b0;
         @(negedge clk);
         chk("R7 late trigger ignored", 32'(busy_o), 32'd0);
      end
   endtask

   task automatic test_reset();
      quiet_chk("R1 reset");
   endtask

   task automatic test_basic();
      run_frame({32'h8000_0001, 32'hDEAD_BEEF, 32'h0000_0000, 32'h1234_5678}, 4'b0101, 0, 1'b0);
      run_frame({32'hFFFF_FFFF, 32'h7FFF_FFFE, 32'hA5A5_5A5A, 32'h0F0F_F0F0}, 4'b1010, 0, 1'b0);
   endtask

   task automatic test_shadow();
      run_frame({32'hCAFE_0001, 32'h0000_8000, 32'h8000_0000, 32'h0000_0003}, 4'b1001, 1, 1'b0);
   endtask

   task automatic test_busy_trigger();
      run_frame({32'h1357_9BDF, 32'h2468_ACE0, 32'hF00D_F00D, 32'h0000_0001}, 4'b0110, 2, 1'b0);
   endtask

   task automatic test_back_to_back();
      logic [N*W-1:0] w = {32'h0BAD_C0DE, 32'h5555_AAAA, 32'h0000_FFFF, 32'hFFFF_0000};
      run_frame(w, 4'b1111, 3, 1'b0);
      run_frame(w, 4'b1111, 0, 1'b1);
   endtask

   task automatic test_enable();
      @(negedge clk);
      en_i = 1'b0;
      trig_i = 1'b1;
      for (int j = 0; j < 6; j++) begin
         @(negedge clk);
         quiet_chk("R8 disabled trigger");
      end
      trig_i = 1'b0;
      en_i = 1'b1;
      @(negedge clk);
      quiet_chk("R8 re-enabled idle");
      words_i = {N{32'hFFFF_FFFF}};
      flags_i = '1;
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
      for (int j = 0; j < 19; j++) @(negedge clk);
      chk("R8 burst running", 32'(busy_o), 32'd1);
      en_i = 1'b0;
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         quiet_chk("R8 abort");
      end
      en_i = 1'b1;
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         quiet_chk("R8 stays idle");
      end
      run_frame({32'h0000_0002, 32'h4000_0000, 32'h9999_6666, 32'h0000_0000}, 4'b0011, 0, 1'b0);
   endtask

   initial begin
      #(5.0 * 200000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      en_i = 1'b1;
      test_basic();
      test_shadow();
      test_busy_trigger();
      test_back_to_back();
      test_enable();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule